// File: doc/BRIEF.md
# Full/Empty Tagged Synchronizing Word Memory

This block is a small word-addressed memory in which every word carries one presence tag bit. The tag marks the word as empty (0) or full (1). Producer and consumer threads can hand single words to each other through it without a separate lock. A producer deposits a value only into an empty word, which marks the word full. A consumer takes a value only from a full word, which marks the word empty again. If the tag is in the wrong state, the memory refuses the request with a trap response and changes nothing, and the requester retries later.

Each request carries a 3-bit operation code:

| Code | Operation | Tag use |
|------|-----------|---------|
| 0 | plain load | ignores and keeps the tag |
| 1 | plain store | ignores and keeps the tag |
| 2 | take | synchronizing load |
| 3 | put | synchronizing store |
| 4 | peek | load that traps on a full word |
| 5 | tag write | writes the tag directly, for initialisation |

Each request is resolved in the cycle it is presented: the tag test, the tag update and the data access all happen at once. The next request already sees the effect of the previous one. The response arrives one cycle after the request. It carries the returned word, a done flag and a trap flag.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset every tag is empty (0): a take (code 2) to any address traps.
- R2: A put (code 3) to an empty word writes the request data, sets the tag to full and responds done=1, trap=0.
- R3: A put to a full word responds trap=1, done=0, and leaves both the stored word and the tag unchanged.
- R4: A take from a full word returns the stored word with done=1, trap=0, and clears the tag to empty.
- R5: A take from an empty word responds trap=1, done=0, returns data 0, and leaves the word and the tag unchanged.
- R6: A peek (code 4) to a full word responds trap=1 and returns data 0. A peek to an empty word returns the stored word with done=1. The tag is unchanged in both cases.
- R7: A plain load (code 0) returns the stored word with done=1. A plain store (code 1) writes the word with done=1. Neither one reads or changes the tag.
- R8: A tag write (code 5) sets the tag of the addressed word to bit 0 of the request data, responds done=1, and leaves the stored word unchanged.
- R9: The response is valid exactly one cycle after each valid request and at no other time. done and trap are never both 1.
- R10: Back-to-back requests to one word take effect in order: each request sees the tag and the data left by the one before it.
- R11: The reserved codes 6 and 7 respond with done=0, trap=0 and data 0, and they change neither the data nor the tags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 3 | Operation code (0 plain load, 1 plain store, 2 take, 3 put, 4 peek, 5 tag write) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data; bit 0 is the tag value for a tag write |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_data | output | DATA_W | Returned word for successful loads, zero otherwise |
| rsp_done | output | 1 | The request completed |
| rsp_trap | output | 1 | The request was refused because of the tag state |

## Verification
The bench builds the block with its defaults: ADDR_W=4 (16 words) and DATA_W=16. With so few words, several thousand random requests return to the same word many times. Each tag therefore goes through both full-to-empty and empty-to-full changes in many orders: take after put, refused puts, and peeks on both tag states. Back-to-back requests to one address are frequent, so the in-order visibility of R10 is exercised by random traffic as well as by the directed cases.

// File: rtl/fe_pkg.sv
package fe_pkg;

  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_TAKE   = 3'd2,
    OP_PUT    = 3'd3,
    OP_PEEK   = 3'd4,
    OP_SETTAG = 3'd5
  } fe_op_e;

  typedef struct packed {
    logic wr_data;
    logic wr_tag;
    logic tag_val;
    logic give;
    logic done;
    logic trap;
  } fe_act_t;

endpackage

// File: rtl/fe_rule.sv
module fe_rule
  import fe_pkg::*;
(
  input  logic [2:0] op,
  input  logic       tag_now,
  input  logic       set_bit,
  output fe_act_t    act
);

  always_comb begin
    act = '0;
    case (fe_op_e'(op))
      OP_LOAD: begin
        act.done = 1'b1;
        act.give = 1'b1;
      end
      OP_STORE: begin
        act.done    = 1'b1;
        act.wr_data = 1'b1;
      end
      OP_TAKE: begin
        if (tag_now) begin
          act.done    = 1'b1;
          act.give    = 1'b1;
          act.wr_tag  = 1'b1;
          act.tag_val = 1'b0;
        end else begin
          act.trap = 1'b1;
        end
      end
      OP_PUT: begin
        if (!tag_now) begin
          act.done    = 1'b1;
          act.wr_data = 1'b1;
          act.wr_tag  = 1'b1;
          act.tag_val = 1'b1;
        end else begin
          act.trap = 1'b1;
        end
      end
      OP_PEEK: begin
        if (tag_now) begin
          act.trap = 1'b1;
        end else begin
          act.done = 1'b1;
          act.give = 1'b1;
        end
      end
      OP_SETTAG: begin
        act.done    = 1'b1;
        act.wr_tag  = 1'b1;
        act.tag_val = set_bit;
      end
      default: act = '0;
    endcase
  end

endmodule

// File: rtl/fe_tag_store.sv
module fe_tag_store #(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_val,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_val,
  output logic [DEPTH-1:0]  tags
);

  logic [DEPTH-1:0] hit;
  logic [DEPTH-1:0] tag_q;

  always_comb begin
    hit = '0;
    if (wr_en) hit[wr_addr] = 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_tag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tag_q[i] <= 1'b0;
      else if (hit[i]) tag_q[i] <= wr_val;
    end
  end

  assign rd_val = tag_q[rd_addr];
  assign tags   = tag_q;

endmodule

// File: rtl/fe_word_store.sv
module fe_word_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [DEPTH-1:0]  hit;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_comb begin
    hit = '0;
    if (wr_en) hit[addr] = 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (hit[i]) mem_q[i] <= wr_data;
    end
  end

  assign rd_data = mem_q[addr];

endmodule

// File: rtl/fe_rsp_stage.sv
module fe_rsp_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_give,
  input  logic              in_done,
  input  logic              in_trap,
  input  logic [DATA_W-1:0] in_word,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_done,
  output logic              rsp_trap
);

  logic [DATA_W-1:0] data_d;
  logic              done_d, trap_d;

  always_comb begin
    data_d = in_give ? in_word : '0;
    done_d = in_valid & in_done;
    trap_d = in_valid & in_trap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_trap  <= 1'b0;
    end else begin
      rsp_valid <= in_valid;
      rsp_done  <= done_d;
      rsp_trap  <= trap_d;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) rsp_data <= data_d;
  end

endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem
  import fe_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_done,
  output logic              rsp_trap
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              tag_now;
  logic [DEPTH-1:0]  tag_vec;
  logic [DATA_W-1:0] word_now;
  fe_act_t           act;

  // Reset asserts at once and is released two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  fe_rule u_rule (
    .op      (req_op),
    .tag_now (tag_now),
    .set_bit (req_wdata[0]),
    .act     (act)
  );

  fe_tag_store #(.ADDR_W(ADDR_W)) u_tags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (req_valid & act.wr_tag),
    .wr_addr (req_addr),
    .wr_val  (act.tag_val),
    .rd_addr (req_addr),
    .rd_val  (tag_now),
    .tags    (tag_vec)
  );

  fe_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_words (
    .clk     (clk),
    .wr_en   (req_valid & act.wr_data),
    .addr    (req_addr),
    .wr_data (req_wdata),
    .rd_data (word_now)
  );

  fe_rsp_stage #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (req_valid),
    .in_give   (act.give),
    .in_done   (act.done),
    .in_trap   (act.trap),
    .in_word   (word_now),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_done  (rsp_done),
    .rsp_trap  (rsp_trap)
  );

endmodule

// File: rtl/fe_sync_mem_chk.sv
module fe_sync_mem_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DEPTH-1:0]  tags,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_done,
  input logic              rsp_trap
);

  // R9: a response follows each request one cycle later
  a_r9_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R9: no response without a request
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R9: done and trap are never raised together
  a_r9_done_trap_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_done && rsp_trap));

  // R3: a put to a full word traps and keeps the tag set
  a_r3_put_full_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd3 && tags[req_addr]) |=> (rsp_trap && tags == $past(tags)));

  // R5: a take from an empty word traps with zero data and keeps the tags
  a_r5_take_empty_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd2 && !tags[req_addr]) |=> (rsp_trap && rsp_data == '0 && tags == $past(tags)));

  // R4: a take from a full word completes and clears the tag
  a_r4_take_full_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd2 && tags[req_addr]) |=> (rsp_done && !tags[$past(req_addr)]));

  // R7: plain accesses leave every tag as it was
  a_r7_plain_keeps_tags: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == 3'd0 || req_op == 3'd1)) |=> tags == $past(tags));

  // R11: reserved codes do nothing
  a_r11_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op[2:1] == 2'b11) |=> (!rsp_done && !rsp_trap && tags == $past(tags)));

  // R6: a peek never changes a tag
  a_r6_peek_keeps_tags: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd4) |=> tags == $past(tags));

endmodule

bind fe_sync_mem fe_sync_mem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_addr  (req_addr),
  .tags      (tag_vec),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .rsp_done  (rsp_done),
  .rsp_trap  (rsp_trap)
);

// File: tb/sim_fe_sync_mem.sv
`timescale 1ns/1ps
module sim_fe_sync_mem;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [2:0]        req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic              rsp_done;
  logic              rsp_trap;

  int tests = 0;
  int fails = 0;

  logic [DATA_W-1:0] ref_data [DEPTH];
  logic              ref_tag  [DEPTH];

  always #4 clk = ~clk;

  fe_sync_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_done(rsp_done), .rsp_trap(rsp_trap)
  );

  function automatic string op_req(input logic [2:0] op, input logic tag);
    case (op)
      3'd0, 3'd1: return "R7";
      3'd2:       return tag ? "R4" : "R5";
      3'd3:       return tag ? "R3" : "R2";
      3'd4:       return "R6";
      3'd5:       return "R8";
      default:    return "R11";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Present one request at a falling edge; its response is checked at the next falling edge.
  task automatic issue(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] wd, input string force_req = "");
    logic [DATA_W-1:0] e_data;
    logic e_done, e_trap, t;
    string req;
    t = ref_tag[a];
    req = (force_req != "") ? force_req : op_req(op, t);
    e_data = '0; e_done = 1'b0; e_trap = 1'b0;
    case (op)
      3'd0: begin e_done = 1; e_data = ref_data[a]; end
      3'd1: begin e_done = 1; ref_data[a] = wd; end
      3'd2: if (t) begin e_done = 1; e_data = ref_data[a]; ref_tag[a] = 0; end
            else e_trap = 1;
      3'd3: if (!t) begin e_done = 1; ref_data[a] = wd; ref_tag[a] = 1; end
            else e_trap = 1;
      3'd4: if (t) e_trap = 1; else begin e_done = 1; e_data = ref_data[a]; end
      3'd5: begin e_done = 1; ref_tag[a] = wd[0]; end
      default: ;
    endcase
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
    @(negedge clk);
    check("R9", "rsp_valid", 32'(rsp_valid), 32'd1);
    check(req, "rsp_data", 32'(rsp_data), 32'(e_data));
    check(req, "rsp_done", 32'(rsp_done), 32'(e_done));
    check(req, "rsp_trap", 32'(rsp_trap), 32'(e_trap));
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(negedge clk);
    check("R9", "rsp_valid idle", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed);
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0;
    for (int i = 0; i < DEPTH; i++) begin ref_tag[i] = 1'b0; ref_data[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", "rsp_valid after reset", 32'(rsp_valid), 32'd0);

    // R1: every word starts empty, so every take traps
    for (int i = 0; i < DEPTH; i++) issue(3'd2, ADDR_W'(i), '0, "R1");
    idle();

    // R7: give every word a known value with plain stores
    for (int i = 0; i < DEPTH; i++) issue(3'd1, ADDR_W'(i), DATA_W'(16'h1000 + i));

    // Directed corner cases on word 3
    issue(3'd3, 4'd3, 16'hA5A5);          // R2 put into empty
    issue(3'd3, 4'd3, 16'hBEEF);          // R3 put into full refused
    issue(3'd0, 4'd3, 16'h0000);          // R3 stored word unchanged (plain load)
    issue(3'd4, 4'd3, 16'h0000);          // R6 peek on full traps
    issue(3'd2, 4'd3, 16'h0000);          // R4 take returns A5A5
    issue(3'd2, 4'd3, 16'h0000);          // R5 second take traps
    issue(3'd4, 4'd3, 16'h0000);          // R6 peek on empty returns data
    // R10: put then take back to back on one word
    issue(3'd3, 4'd7, 16'h1234, "R10");
    issue(3'd2, 4'd7, 16'h0000, "R10");
    issue(3'd3, 4'd7, 16'h5678, "R10");
    // R8: tag write then plain store keeps tag, take sees new word
    issue(3'd5, 4'd5, 16'h0001);
    issue(3'd0, 4'd5, 16'h0000, "R8");
    issue(3'd1, 4'd5, 16'hC0DE);
    issue(3'd2, 4'd5, 16'h0000, "R7");
    issue(3'd5, 4'd9, 16'hFFFE);          // R8 tag write of 0 keeps empty
    issue(3'd2, 4'd9, 16'h0000, "R8");
    // R11: reserved codes do nothing, then the word still behaves as before
    issue(3'd6, 4'd7, 16'hDEAD);
    issue(3'd7, 4'd7, 16'hDEAD);
    issue(3'd0, 4'd7, 16'h0000, "R11");
    issue(3'd2, 4'd7, 16'h0000, "R11");
    idle();

    // Random traffic against the reference model
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 8) idle();
      else begin
        logic [2:0] op;
        int s;
        s = $urandom_range(0, 99);
        if      (s < 25) op = 3'd3;
        else if (s < 50) op = 3'd2;
        else if (s < 62) op = 3'd4;
        else if (s < 74) op = 3'd0;
        else if (s < 84) op = 3'd1;
        else if (s < 94) op = 3'd5;
        else             op = 3'($urandom_range(6, 7));
        issue(op, ADDR_W'($urandom_range(0, DEPTH - 1)), DATA_W'($urandom));
      end
    end
    idle();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule